// File: doc/BRIEF.md
# Dual-Tap Timing Marker Delay Line

This block accepts five single-bit timing markers from the master timing source and produces two delayed copies of all five on the helper clock. The markers are, by bit position: bit 0 beginning of turn, bit 1 live crossing, bit 2 sync gap, bit 3 cosmic gap, bit 4 spare.

The short copy feeds the serial command link. It trails the input by two ticks, so that the beginning-of-turn marker lines up with a tick scaler that reaches tick 1 two ticks after it sees that marker. The other four channels get the same two-tick latency so that every channel is processed the same way.

The long copy is an input term for the trigger framework. It trails the input by twenty-five ticks, which is twenty-three ticks beyond the short copy. This shift takes each marker from the front-end time zone into the framework time zone, where framework tick 1 coincides with front-end tick 25. The long copy is launched on the falling clock edge, which gives the downstream logic about half a period of extra setup before its next rising edge.

Both copies are tapped from one shift chain per channel that advances on rising edges. The long tap passes through one last register clocked on the falling edge.

Top module: `markerDelayLine`

## Requirements
- R1: A marker value applied in the cycle after rising edge n appears on `linkMark` in the cycle after rising edge n+2, with exactly two ticks of latency.
- R2: All five channels have identical latency on both outputs, whichever channels are active at the same time.
- R3: A marker value applied after rising edge n is present on `trigMark` when the rising edge n+25 occurs, with 25 ticks of total latency.
- R4: `trigMark` changes only on falling clock edges. The value seen after the falling edge that follows rising edge m is the input that was applied after rising edge m-24.
- R5: While `rst` is high at a clock edge, every delay stage and both outputs clear to 0. After `rst` is released, no marker appears on either output until a new marker has travelled through the chain.
- R6: A one-cycle pulse at the input gives exactly one one-cycle pulse on each output at that output's latency. Pulses on consecutive cycles stay separate and in order.
- R7: The bit order is kept from input to both outputs (bit 0 beginning of turn, bit 1 live crossing, bit 2 sync gap, bit 3 cosmic gap, bit 4 spare). No marker leaks into another channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Helper clock; the chain advances on its rising edges and the long output on its falling edges |
| rst | input | 1 | Synchronous reset, active high |
| markIn | input | 5 | Incoming timing markers, bit 0 beginning of turn up to bit 4 spare |
| linkMark | output | 5 | Copy for the serial command link, two ticks late |
| trigMark | output | 5 | Trigger-framework copy, twenty-five ticks late, launched on the falling edge |

## Verification
On every cycle the assertions check the two-tick match between the input and the link output. They also check that the falling-edge register passes on the tail of the chain a half period later, and that the stages and outputs are cleared after a reset edge. Only the bench's scenarios show the full twenty-five-tick arrival, and they use a history of applied inputs to do so. The same scenarios show that single and back-to-back pulses arrive as exactly one pulse each, that walking patterns keep every channel in its own bit, and that a reset in mid-stream discards the markers already in flight.

// File: rtl/markerDelayPkg.sv
package markerDelayPkg;
  localparam int unsigned MARK_COUNT = 5;
  localparam int unsigned LINK_TAP   = 2;
  localparam int unsigned TRIG_TAP   = 25;

  // strobes handed from control to datapath, one per clock edge domain
  typedef struct packed {
    logic clearRise;
    logic clearFall;
  } ctrlStrobe_t;
endpackage

// File: rtl/markerDelayCtrl.sv
module markerDelayCtrl
  import markerDelayPkg::*;
(
  input  logic        rst,
  output ctrlStrobe_t strobe
);
  // the synchronous reset is sampled separately by each edge domain
  always_comb begin
    strobe.clearRise = rst;
    strobe.clearFall = rst;
  end
endmodule

// File: rtl/markerDelayChain.sv
module markerDelayChain #(
  parameter int unsigned markWidth  = 5,
  parameter int unsigned linkTap    = 2,
  parameter int unsigned chainDepth = 24
) (
  input  logic                 clk,
  input  logic                 clearStages,
  input  logic [markWidth-1:0] markIn,
  output logic [markWidth-1:0] linkMark,
  output logic [markWidth-1:0] chainTail
);
  logic [markWidth-1:0] stage [chainDepth];

  for (genvar i = 0; i < chainDepth; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (clearStages) stage[i] <= '0;
        else             stage[i] <= markIn;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (clearStages) stage[i] <= '0;
        else             stage[i] <= stage[i-1];
      end
    end
  end

  assign linkMark  = stage[linkTap-1];
  assign chainTail = stage[chainDepth-1];
endmodule

// File: rtl/markerFallLaunch.sv
module markerFallLaunch #(
  parameter int unsigned markWidth = 5
) (
  input  logic                 clk,
  input  logic                 clearOut,
  input  logic [markWidth-1:0] chainTail,
  output logic [markWidth-1:0] trigMark
);
  always_ff @(negedge clk) begin
    if (clearOut) trigMark <= '0;
    else          trigMark <= chainTail;
  end
endmodule

// File: rtl/markerDelayLine.sv
module markerDelayLine
  import markerDelayPkg::*;
#(
  parameter int unsigned markWidth = MARK_COUNT,
  parameter int unsigned linkTap   = LINK_TAP,
  parameter int unsigned trigTap   = TRIG_TAP
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [markWidth-1:0] markIn,
  output logic [markWidth-1:0] linkMark,
  output logic [markWidth-1:0] trigMark
);
  // the falling-edge launch register supplies the last tick of the long tap
  localparam int unsigned chainDepth = trigTap - 1;

  ctrlStrobe_t          strobe;
  logic [markWidth-1:0] chainTail;

  markerDelayCtrl u_ctrl (
    .rst    (rst),
    .strobe (strobe)
  );

  markerDelayChain #(
    .markWidth  (markWidth),
    .linkTap    (linkTap),
    .chainDepth (chainDepth)
  ) u_chain (
    .clk         (clk),
    .clearStages (strobe.clearRise),
    .markIn      (markIn),
    .linkMark    (linkMark),
    .chainTail   (chainTail)
  );

  markerFallLaunch #(
    .markWidth (markWidth)
  ) u_launch (
    .clk       (clk),
    .clearOut  (strobe.clearFall),
    .chainTail (chainTail),
    .trigMark  (trigMark)
  );
endmodule

// File: rtl/markerDelayLineChecker.sv
module markerDelayLineChecker #(
  parameter int unsigned markWidth = 5,
  parameter int unsigned linkTap   = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic [markWidth-1:0] markIn,
  input logic [markWidth-1:0] linkMark,
  input logic [markWidth-1:0] trigMark,
  input logic [markWidth-1:0] chainTail
);
  // rising edges seen since the last reset edge, saturating
  logic [7:0] sinceRst;
  always_ff @(posedge clk) begin
    if (rst)                 sinceRst <= '0;
    else if (sinceRst != '1) sinceRst <= sinceRst + 8'd1;
  end

  // R1, R2: every channel of the short tap trails the input by the same two ticks
  a_r1_link_delay: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 8'(linkTap)) |-> (linkMark == $past(markIn, linkTap)));

  // R4: the long output takes up the chain tail at the falling edge, so at the
  // next rising edge it holds the value the tail had during that cycle
  a_r4_fall_launch: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 8'd1) |-> (trigMark == chainTail));

  // R5: a reset edge clears the stages and the link output
  a_r5_link_cleared: assert property (@(posedge clk)
    rst |=> (linkMark == '0 && chainTail == '0));

  // R5: the long output is clear by the rising edge that follows a reset edge
  a_r5_trig_cleared: assert property (@(posedge clk)
    rst |=> (trigMark == '0));
endmodule

bind markerDelayLine markerDelayLineChecker #(
  .markWidth (markWidth),
  .linkTap   (linkTap)
) u_check (
  .clk       (clk),
  .rst       (rst),
  .markIn    (markIn),
  .linkMark  (linkMark),
  .trigMark  (trigMark),
  .chainTail (chainTail)
);

// File: tb/markerDelayLine_bench.sv
module markerDelayLine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HIST = 4096;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] markIn = '0;
  logic [4:0] linkMark;
  logic [4:0] trigMark;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [4:0] hist [HIST];

  markerDelayLine u_markerDelayLine (
    .clk      (clk),
    .rst      (rst),
    .markIn   (markIn),
    .linkMark (linkMark),
    .trigMark (trigMark)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [4:0] past(input int idx);
    if (idx < 0) return 5'b0;
    return hist[idx];
  endfunction

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %b expected %b", req, cyc, act, exp);
    end
  endtask

  // one clock: check the outputs after the rising edge, drive new inputs,
  // then check the falling-edge output
  task automatic step(input logic [4:0] v, input logic r, input string tag);
    @(posedge clk);
    cyc++;
    #2;
    if (cyc >= 2) begin
      chk({tag, " R1 link"}, linkMark, past(cyc - 2));
      chk({tag, " R3 trig"}, trigMark, past(cyc - 25));
    end
    markIn = v;
    rst    = r;
    if (r) begin
      for (int k = 0; k <= cyc; k++) hist[k] = '0;
    end else begin
      hist[cyc] = v;
    end
    #5;
    if (cyc >= 2) chk({tag, " R4 fall"}, trigMark, past(cyc - 24));
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(5'b0, 1'b0, tag);
  endtask

  task automatic t_reset;
    for (int k = 0; k < 3; k++) step(5'b0, 1'b1, "R5 reset");
    chk("R5 reset link", linkMark, 5'b0);
    chk("R5 reset trig", trigMark, 5'b0);
    step(5'b0, 1'b0, "R5 release");
    idle(28, "R5 refill");
  endtask

  task automatic t_single_pulse;
    step(5'b00001, 1'b0, "R6 single");
    idle(28, "R6 single");
  endtask

  task automatic t_back_to_back;
    step(5'b00100, 1'b0, "R6 b2b");
    step(5'b00100, 1'b0, "R6 b2b");
    step(5'b00000, 1'b0, "R6 b2b");
    step(5'b00100, 1'b0, "R6 b2b");
    idle(28, "R6 b2b");
  endtask

  task automatic t_walking;
    for (int b = 0; b < 5; b++) step(5'(1 << b), 1'b0, "R7 walk");
    for (int b = 0; b < 5; b++) step(~5'(1 << b), 1'b0, "R7 walk0");
    idle(28, "R7 walk");
  endtask

  task automatic t_all_channels;
    step(5'b11111, 1'b0, "R2 all");
    step(5'b10101, 1'b0, "R2 mix");
    step(5'b01010, 1'b0, "R2 mix");
    step(5'b11111, 1'b0, "R2 all");
    idle(28, "R2 all");
  endtask

  task automatic t_mid_reset;
    for (int k = 0; k < 10; k++) step(5'(k * 7 + 3), 1'b0, "R5 fill");
    step(5'b0, 1'b1, "R5 mid");
    step(5'b0, 1'b0, "R5 mid");
    chk("R5 mid link", linkMark, 5'b0);
    idle(28, "R5 flushed");
  endtask

  initial begin
    for (int k = 0; k < HIST; k++) hist[k] = '0;
    t_reset();
    t_single_pulse();
    t_back_to_back();
    t_walking();
    t_all_channels();
    t_mid_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule